// File: doc/BRIEF.md
# Page Programming Cycle Sequencer

This block runs the internal programming cycle of a nonvolatile byte memory after a serial write frame has been closed. The bus controller gives it one commit pulse. The pulse carries three things: the page number, a lane mask saying which of the page-latch bytes hold new data, and the contents of the latch. From that point the sequencer alone drives the memory array. It does so through a single byte-wide write strobe with an address and a data byte. It holds `busy` high for the whole cycle, and the bus controller uses that flag to refuse new accesses.

The sequencer picks its mode from the mask:

- **Page mode** (two or more lanes set). It runs one block-erase interval, in which every masked lane is overwritten with all ones. It then runs one programming interval per masked lane, taken in ascending lane order.
- **Byte mode** (exactly one lane set). It runs a single, longer combined erase/write interval.

All intervals are built from a free-running clock. A prescaler divides the clock, and a tick counter counts the prescaled ticks. The lengths are parameters in prescaled ticks, so a testbench can shorten them. When the sequence ends there is one cycle in which `busy` is low and a latch-invalidate pulse is raised. A commit that arrives while the sequencer is busy is dropped, and a sticky overrun flag records it.

Top module: `pgm_cycle_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `overrun`, `latch_clr` and `arr_we` are all low.
- R2: A `cm_valid` pulse with a nonzero `cm_mask`, sampled at a clock edge where `busy` is low, starts a sequence. `busy` is high from the next cycle until the last array strobe, including that strobe's cycle.
- R3: In page mode (two or more mask bits set), the first interval lasts ERASE_TICKS*PRESC_DIV cycles. In its cycle k, for k from 0 to PAGE_BYTES-1, `arr_we` is high exactly when mask bit k is set, and it carries data all ones to lane k.
- R4: In page mode, after the erase interval, each set mask lane gets one interval of STEP_TICKS*PRESC_DIV cycles, taken in ascending lane order. Each interval ends with one strobe in its last cycle. The strobe writes latch byte k, which is `cm_data[DATA_W*k +: DATA_W]`.
- R5: A lane whose mask bit is clear is never strobed, in either mode.
- R6: In byte mode (exactly one mask bit set), there is no erase interval. A single interval of BYTE_TICKS*PRESC_DIV cycles runs, with one data strobe in its last cycle.
- R7: Every strobe address is `{page, lane}`: the page number in the upper ADDR_W-IDX_W bits and the lane index in the low IDX_W bits.
- R8: The cycle after the last strobe has `busy` low and `latch_clr` high, for exactly one cycle. The block is then idle.
- R9: A `cm_valid` sampled while `busy` is high has no effect on the running sequence. It sets `overrun` from the next cycle, and `overrun` then stays high until reset.
- R10: A `cm_valid` with an all-zero mask is ignored. `busy` stays low and `overrun` does not change.
- R11: A commit sampled during the `latch_clr` cycle is accepted as a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | Commit pulse from the bus controller |
| cm_page | input | ADDR_W-IDX_W | Page number (upper address bits) |
| cm_mask | input | PAGE_BYTES | Lane mask: one bit per latch byte holding new data |
| cm_data | input | PAGE_BYTES*DATA_W | Page-latch contents, lane k at bits DATA_W*k upward |
| busy | output | 1 | Programming cycle in progress |
| overrun | output | 1 | Sticky flag: a commit arrived while busy |
| latch_clr | output | 1 | One-cycle pulse that invalidates the page latch |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array byte write data |

## Verification
The bench builds the block with the following shortened timing:

| Parameter | Value | Resulting interval |
|---|---|---|
| PRESC_DIV | 4 | — |
| ERASE_TICKS | 3 | erase: 12 cycles |
| STEP_TICKS | 2 | per-byte program step: 8 cycles |
| BYTE_TICKS | 5 | byte-mode cycle: 20 cycles |

With these values a full eight-lane page, a sparse page, a two-lane page and a byte-mode commit all complete within a few hundred cycles. Each of them can then be compared cycle by cycle against a queue-driven model.

The erase interval is still longer than the eight-cycle erase strobe walk. This keeps the strobe sweep and the interval end visibly separate. The overrun, empty-mask and back-to-back commit cases fall inside the same short windows.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERASE = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_DONE  = 2'd3
   } sq_state_e;

endpackage

// File: rtl/pgm_ivl_timer.sv
// Prescaler plus tick counter; done marks the final clock of an interval.
module pgm_ivl_timer #(
   parameter int PRESC_DIV = 128,
   parameter int TK_W      = 8,
   localparam int PRE_W    = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [TK_W-1:0] len,
   output logic            done
);

   logic [PRE_W-1:0] pre_cnt;
   logic [TK_W-1:0]  tick_cnt;
   logic             pre_wrap;

   assign pre_wrap = (pre_cnt == PRE_W'(PRESC_DIV - 1));
   assign done     = pre_wrap && (tick_cnt == (len - TK_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         tick_cnt <= '0;
      end else if (restart) begin
         pre_cnt  <= '0;
         tick_cnt <= '0;
      end else if (pre_wrap) begin
         pre_cnt  <= '0;
         tick_cnt <= tick_cnt + TK_W'(1);
      end else begin
         pre_cnt  <= pre_cnt + PRE_W'(1);
      end
   end

endmodule

// File: rtl/pgm_lane_pick.sv
// Lowest-set-lane picker with single-lane detection.
module pgm_lane_pick #(
   parameter int N      = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any,
   output logic             single
);

   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;

   for (genvar g = 0; g < N; g++) begin : g_chain
      assign first[g]  = vec[g] & ~seen[g];
      assign seen[g+1] = seen[g] | vec[g];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = idx | IDX_W'(i);
      end
   end

   assign any    = seen[N];
   assign single = any && ((vec & ~first) == '0);

endmodule

// File: rtl/pgm_cycle_seq.sv
module pgm_cycle_seq
   import pgm_seq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 8,
   parameter int ADDR_W      = 8,
   parameter int PRESC_DIV   = 128,
   parameter int ERASE_TICKS = 16,
   parameter int STEP_TICKS  = 16,
   parameter int BYTE_TICKS  = 46,
   localparam int IDX_W      = $clog2(PAGE_BYTES),
   localparam int PAGE_W     = ADDR_W - IDX_W,
   localparam int MAX_TICKS  = (BYTE_TICKS > ERASE_TICKS)
                               ? ((BYTE_TICKS > STEP_TICKS) ? BYTE_TICKS : STEP_TICKS)
                               : ((ERASE_TICKS > STEP_TICKS) ? ERASE_TICKS : STEP_TICKS),
   localparam int TK_W       = $clog2(MAX_TICKS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cm_valid,
   input  logic [PAGE_W-1:0]            cm_page,
   input  logic [PAGE_BYTES-1:0]        cm_mask,
   input  logic [PAGE_BYTES*DATA_W-1:0] cm_data,
   output logic                         busy,
   output logic                         overrun,
   output logic                         latch_clr,
   output logic                         arr_we,
   output logic [ADDR_W-1:0]            arr_addr,
   output logic [DATA_W-1:0]            arr_wdata
);

   if (PAGE_BYTES < 2 || (1 << IDX_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (PRESC_DIV < 2) begin : g_bad_presc
      $error("PRESC_DIV must be at least 2");
   end
   if (ERASE_TICKS < 1 || STEP_TICKS < 1 || BYTE_TICKS < 1) begin : g_bad_ticks
      $error("interval lengths must be at least one tick");
   end
   if (PRESC_DIV * ERASE_TICKS < PAGE_BYTES) begin : g_bad_erase
      $error("erase interval shorter than the erase strobe walk");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the lane index width");
   end

   sq_state_e                   st;
   logic [PAGE_BYTES-1:0]       mask_q;
   logic [PAGE_BYTES-1:0]       rem_q;
   logic [PAGE_W-1:0]           page_q;
   logic [PAGE_BYTES*DATA_W-1:0] data_q;
   logic                        byte_mode_q;
   logic [IDX_W:0]              e_cnt;

   logic [IDX_W-1:0]            cur;
   logic                        rem_any;
   logic                        rem_single;
   logic [IDX_W-1:0]            cm_first;
   logic                        cm_any;
   logic                        cm_single;
   logic                        accept;
   logic                        ivl_done;
   logic                        restart;
   logic [TK_W-1:0]             len;
   logic                        e_walk;
   logic [PAGE_BYTES-1:0]       rem_next;

   pgm_lane_pick #(.N(PAGE_BYTES)) u_pick_rem (
      .vec    (rem_q),
      .idx    (cur),
      .any    (rem_any),
      .single (rem_single)
   );

   pgm_lane_pick #(.N(PAGE_BYTES)) u_pick_cm (
      .vec    (cm_mask),
      .idx    (cm_first),
      .any    (cm_any),
      .single (cm_single)
   );

   assign busy    = (st == SQ_ERASE) || (st == SQ_WRITE);
   assign accept  = cm_valid && !busy && cm_any;
   assign restart = accept || (busy && ivl_done);

   always_comb begin
      case (st)
         SQ_ERASE: len = TK_W'(ERASE_TICKS);
         SQ_WRITE: len = byte_mode_q ? TK_W'(BYTE_TICKS) : TK_W'(STEP_TICKS);
         default:  len = TK_W'(STEP_TICKS);
      endcase
   end

   pgm_ivl_timer #(.PRESC_DIV(PRESC_DIV), .TK_W(TK_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .len     (len),
      .done    (ivl_done)
   );

   assign e_walk = (st == SQ_ERASE) && !e_cnt[IDX_W];

   always_comb begin
      rem_next      = rem_q;
      rem_next[cur] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SQ_IDLE;
         mask_q      <= '0;
         rem_q       <= '0;
         page_q      <= '0;
         data_q      <= '0;
         byte_mode_q <= 1'b0;
         e_cnt       <= '0;
         overrun     <= 1'b0;
      end else begin
         if (cm_valid && busy) overrun <= 1'b1;
         if (e_walk) e_cnt <= e_cnt + (IDX_W+1)'(1);
         case (st)
            SQ_ERASE: if (ivl_done) st <= SQ_WRITE;
            SQ_WRITE: if (ivl_done) begin
               rem_q <= rem_next;
               if (rem_next == '0) st <= SQ_DONE;
            end
            default: st <= SQ_IDLE;
         endcase
         if (accept) begin
            mask_q      <= cm_mask;
            rem_q       <= cm_mask;
            page_q      <= cm_page;
            data_q      <= cm_data;
            byte_mode_q <= cm_single;
            e_cnt       <= '0;
            st          <= cm_single ? SQ_WRITE : SQ_ERASE;
         end
      end
   end

   always_comb begin
      arr_we    = 1'b0;
      arr_addr  = {page_q, cur};
      arr_wdata = data_q[cur*DATA_W +: DATA_W];
      if (st == SQ_ERASE) begin
         arr_addr  = {page_q, e_cnt[IDX_W-1:0]};
         arr_wdata = '1;
         arr_we    = e_walk && mask_q[e_cnt[IDX_W-1:0]];
      end else if (st == SQ_WRITE) begin
         arr_we = ivl_done && rem_any;
      end
   end

   assign latch_clr = (st == SQ_DONE);

   logic unused_ok;
   assign unused_ok = ^{cm_first, rem_single};

endmodule

// File: rtl/pgm_cycle_seq_chk.sv
module pgm_cycle_seq_chk #(
   parameter int PAGE_BYTES = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cm_valid,
   input logic [PAGE_BYTES-1:0] cm_mask,
   input logic                  busy,
   input logic                  overrun,
   input logic                  latch_clr,
   input logic                  arr_we
);

   // R2: accepted commit raises busy on the next cycle
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && !busy && (cm_mask != '0)) |=> busy);

   // R10: empty mask leaves the block idle
   p_empty_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && !busy && (cm_mask == '0)) |=> !busy);

   // R9: commit during busy sets the sticky flag
   p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && busy) |=> overrun);

   // R9: flag never clears without reset
   p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R8: end of busy is always marked by the latch invalidate pulse
   p_end_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> latch_clr);

   // R8: invalidate pulse is a single quiet cycle
   p_clr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_clr |-> (!busy && !arr_we) ##1 !latch_clr);

   // R2: array strobes only happen inside the busy window
   p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

endmodule

bind pgm_cycle_seq pgm_cycle_seq_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cm_valid  (cm_valid),
   .cm_mask   (cm_mask),
   .busy      (busy),
   .overrun   (overrun),
   .latch_clr (latch_clr),
   .arr_we    (arr_we)
);

// File: tb/pgm_cycle_seq_tb.sv
module pgm_cycle_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int PB   = 8;
   localparam int DW   = 8;
   localparam int AW   = 8;
   localparam int PRE  = 4;
   localparam int ET   = 3;
   localparam int STT  = 2;
   localparam int BT   = 5;
   localparam int IW   = 3;
   localparam int PW   = AW - IW;

   typedef struct {
      bit          busy;
      bit          we;
      bit          clr;
      logic [7:0]  addr;
      logic [7:0]  data;
      string       tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cm_valid = 1'b0;
   logic [PW-1:0]      cm_page = '0;
   logic [PB-1:0]      cm_mask = '0;
   logic [PB*DW-1:0]   cm_data = '0;
   logic               busy, overrun, latch_clr, arr_we;
   logic [AW-1:0]      arr_addr;
   logic [DW-1:0]      arr_wdata;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit model_on = 1'b0;
   bit exp_ovr  = 1'b0;
   exp_t q[$];
   logic [7:0] mem [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   pgm_cycle_seq #(
      .DATA_W(DW), .PAGE_BYTES(PB), .ADDR_W(AW), .PRESC_DIV(PRE),
      .ERASE_TICKS(ET), .STEP_TICKS(STT), .BYTE_TICKS(BT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cm_valid(cm_valid), .cm_page(cm_page),
      .cm_mask(cm_mask), .cm_data(cm_data), .busy(busy), .overrun(overrun),
      .latch_clr(latch_clr), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic exp_t mk(bit b, bit w, bit c, logic [7:0] a, logic [7:0] d, string t);
      exp_t e;
      e.busy = b; e.we = w; e.clr = c; e.addr = a; e.data = d; e.tag = t;
      return e;
   endfunction

   // Expected cycle stream for one accepted commit
   task automatic build(input logic [PW-1:0] pg, input logic [PB-1:0] m, input logic [PB*DW-1:0] d);
      if ($countones(m) == 1) begin
         for (int j = 0; j < PB; j++) begin
            if (m[j]) begin
               for (int c = 0; c < BT*PRE-1; c++) q.push_back(mk(1, 0, 0, 0, 0, "R6"));
               q.push_back(mk(1, 1, 0, {pg, IW'(j)}, d[j*DW +: DW], "R6"));
            end
         end
      end else begin
         for (int c = 0; c < ET*PRE; c++) begin
            if (c < PB && m[c]) q.push_back(mk(1, 1, 0, {pg, IW'(c)}, 8'hFF, "R3"));
            else                q.push_back(mk(1, 0, 0, 0, 0, "R5"));
         end
         for (int j = 0; j < PB; j++) begin
            if (m[j]) begin
               for (int c = 0; c < STT*PRE-1; c++) q.push_back(mk(1, 0, 0, 0, 0, "R4"));
               q.push_back(mk(1, 1, 0, {pg, IW'(j)}, d[j*DW +: DW], "R4"));
            end
         end
      end
      q.push_back(mk(0, 0, 1, 0, 0, "R8"));
   endtask

   // Model advance at the active edge
   always @(posedge clk) begin
      cyc++;
      if (arr_we) mem[arr_addr] <= arr_wdata;
      if (model_on) begin
         bit was_busy;
         was_busy = 1'b0;
         if (q.size() != 0) begin
            was_busy = q[0].busy;
            void'(q.pop_front());
         end
         if (cm_valid) begin
            if (was_busy) exp_ovr = 1'b1;
            else if (cm_mask != '0) build(cm_page, cm_mask, cm_data);
         end
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (model_on) begin
         exp_t e;
         if (q.size() != 0) e = q[0];
         else e = mk(0, 0, 0, 0, 0, "R5");
         chk(busy == e.busy, "R2 busy", busy, e.busy);
         chk(latch_clr == e.clr, "R8 latch_clr", latch_clr, e.clr);
         chk(arr_we == e.we, {e.tag, " arr_we"}, arr_we, e.we);
         if (e.we && arr_we) begin
            chk(arr_addr == e.addr, "R7 arr_addr", arr_addr, e.addr);
            chk(arr_wdata == e.data, {e.tag, " arr_wdata"}, arr_wdata, e.data);
         end
         chk(overrun == exp_ovr, "R9 overrun", overrun, exp_ovr);
      end
   end

   always @(posedge clk) begin
      if (cyc > 50000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic commit(input logic [PW-1:0] pg, input logic [PB-1:0] m, input logic [PB*DW-1:0] d);
      @(negedge clk);
      cm_valid = 1'b1; cm_page = pg; cm_mask = m; cm_data = d;
      @(negedge clk);
      cm_valid = 1'b0;
   endtask

   task automatic wait_quiet();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [PB*DW-1:0] pat(input logic [7:0] seed);
      logic [PB*DW-1:0] v;
      for (int k = 0; k < PB; k++) v[k*DW +: DW] = seed + 8'(k * 17);
      return v;
   endfunction

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = 8'h5A;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !overrun && !latch_clr && !arr_we, "R1 reset outputs",
          {busy, overrun, latch_clr, arr_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !overrun && !latch_clr && !arr_we, "R1 after release",
          {busy, overrun, latch_clr, arr_we}, 0);
      model_on = 1'b1;

      // R3 R4: full page
      commit(5'd3, 8'hFF, pat(8'h10));
      wait_quiet();
      for (int k = 0; k < PB; k++)
         chk(mem[{5'd3, 3'(k)}] == 8'(8'h10 + k*17), "R4 full page content",
             mem[{5'd3, 3'(k)}], 8'(8'h10 + k*17));

      // R5: sparse page, unmasked lanes untouched
      commit(5'd5, 8'hA6, pat(8'h33));
      wait_quiet();
      for (int k = 0; k < PB; k++) begin
         if (k == 1 || k == 2 || k == 5 || k == 7)
            chk(mem[{5'd5, 3'(k)}] == 8'(8'h33 + k*17), "R4 sparse lane",
                mem[{5'd5, 3'(k)}], 8'(8'h33 + k*17));
         else
            chk(mem[{5'd5, 3'(k)}] == 8'h5A, "R5 unmasked lane",
                mem[{5'd5, 3'(k)}], 8'h5A);
      end

      // R6: byte mode
      commit(5'd9, 8'h10, pat(8'hC0));
      wait_quiet();
      chk(mem[{5'd9, 3'd4}] == 8'(8'hC0 + 68), "R6 byte lane",
          mem[{5'd9, 3'd4}], 8'(8'hC0 + 68));
      chk(mem[{5'd9, 3'd3}] == 8'h5A, "R6 neighbour untouched", mem[{5'd9, 3'd3}], 8'h5A);

      // R10: empty mask
      commit(5'd2, 8'h00, pat(8'h01));
      chk(!busy && !overrun, "R10 empty mask", {busy, overrun}, 0);
      wait_quiet();

      // R7 R4: two-lane page at the top page number, ends of lane range
      commit(5'd31, 8'h81, pat(8'h70));
      // R9: commit while busy
      repeat (4) @(negedge clk);
      commit(5'd0, 8'hFF, pat(8'h00));
      chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
      // R11: commit in the invalidate cycle
      while (!latch_clr) @(negedge clk);
      cm_valid = 1'b1; cm_page = 5'd12; cm_mask = 8'h02; cm_data = pat(8'h44);
      @(negedge clk);
      cm_valid = 1'b0;
      chk(busy == 1'b1, "R11 accepted in clear cycle", busy, 1);
      wait_quiet();
      chk(mem[{5'd31, 3'd0}] == 8'h70 && mem[{5'd31, 3'd7}] == 8'(8'h70 + 119),
          "R7 top page lanes", mem[{5'd31, 3'd7}], 8'(8'h70 + 119));
      chk(mem[{5'd0, 3'd0}] == 8'h5A, "R9 dropped commit not written", mem[{5'd0, 3'd0}], 8'h5A);
      chk(mem[{5'd12, 3'd1}] == 8'(8'h44 + 17), "R11 new sequence data",
          mem[{5'd12, 3'd1}], 8'(8'h44 + 17));
      chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule